// File: doc/BRIEF.md
# Accumulating ADC Slot Sequencer

The sequencer sits between a register bus and a single shared analog-to-digital converter. It keeps eight virtual conversion slots. Each slot has a 4-bit selector that points it at one of sixteen physical input channels. Each slot also holds an 18-bit unsigned result that a conversion either replaces or adds to. Software writes start bits, and a scheduler raises per-slot start pulses. Both mark slots as pending. The sequencer hands pending slots to the converter one at a time, lowest slot first, and routes each result back to the slot that asked for it.

A slot in accumulate mode sums a programmed number of samples (count + 1) before it reports completion. A slot outside accumulate mode reports completion after every sample. Completion sets a sticky status bit, and each status bit has its own enable. The single interrupt output is high while any enabled status bit is set. Status bits are cleared by writing ones to a clear alias.

Top module: `adc_slot_seq`

Register map (4-bit word address). Address 0 holds the interrupt register: slot status at bits [7:0] and enables at bits [23:16]. A write to address 0 loads the enables and leaves status alone. Address 3 is the clear alias, where a 1 clears the status bit or enable bit at the same position. Address 4 is the map register, with the selector for slot s at bits [4s+3:4s]. Address 5 is the start register, with bit s requesting slot s. It reads as 0. Addresses 8 to 15 are the slot registers for slots 0 to 7. A slot register has the accumulate flag at bit 29, the sample count at bits [28:24] and the result at bits [17:0].

## Requirements
- R1: After reset, the interrupt register, the map register and every slot register read 0, irq is low and conv_start is low.
- R2: A conversion for slot s is issued with conv_chan equal to map register bits [4s+3:4s].
- R3: With the accumulate flag (bit 29) at 0, each conversion overwrites the result field and sets status bit s.
- R4: With the accumulate flag at 1 and count field c, each sample is added to the result modulo 2^18. Status bit s is set on sample c+1 and not before. The sample counter then restarts.
- R5: A write to a slot register loads the flag, the count and the result from the written bits and restarts the sample counter. Writing 0 therefore clears the result and the count.
- R6: Writing 1 to start-register bit s (address 5) or pulsing sched_start[s] makes slot s pending.
- R7: Pending slots are issued in ascending slot order. A new conv_start is only issued after the previous conv_done.
- R8: Status bits are sticky and set on completion even when their enable is 0. irq is high exactly when some status bit and its enable (bit 16+s) are both 1.
- R9: Writing 1 at bit s of the clear alias (address 3) clears status bit s, and writing 1 at bit 16+s clears enable s. Bits written with 0 are unchanged.
- R10: Start requests for a slot that is already pending merge into a single conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| sched_start | input | 8 | Per-slot start pulses from a scheduler |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_chan | output | 4 | Physical channel for the request |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 18 | Converter result |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check, on every cycle, that at most one slot is granted and that a grant is followed by a busy converter. They also check that status bits only rise on a completion and never fall without a clear, that a result changes only on a write or a routed sample, and that a zero write leaves a zero result. What the assertions cannot see is end-to-end behaviour: that issue order is ascending, that duplicate starts merge, that sums wrap correctly, and that channel remapping reaches the converter. The bench shows these through a converter model that logs every request and through randomized slot programs whose results are compared with computed sums.

// File: rtl/adc_seq_pkg.sv
// Shared constants for the slot sequencer: register word addresses and
// field positions of the slot register.
package adc_seq_pkg;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 32;
    localparam logic [ADDR_W-1:0] A_IRQ   = 4'd0;
    localparam logic [ADDR_W-1:0] A_CLR   = 4'd3;
    localparam logic [ADDR_W-1:0] A_MAP   = 4'd4;
    localparam logic [ADDR_W-1:0] A_START = 4'd5;
    localparam int EN_POS      = 16;
    localparam int ACC_POS     = 29;
    localparam int CNT_POS     = 24;
endpackage

// File: rtl/seq_arbiter.sv
// Pending-slot tracker and fixed-priority issuer.
// Holds one pending bit per slot and issues the lowest pending slot when the
// converter is idle. It stays busy until conv_done arrives.
// Assumes conv_done is only meaningful while busy; a stray strobe is ignored.
module seq_arbiter #(
    parameter int N_SLOTS = 8,
    localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] req_set,
    input  logic               done_in,
    output logic               launch_o,
    output logic [IDX_W-1:0]   pick_o,
    output logic               busy_o,
    output logic [IDX_W-1:0]   active_o
);
    logic [N_SLOTS-1:0] pending_q;
    logic [N_SLOTS-1:0] grant;
    logic               any_pend;

    // lowest-index pending slot
    always_comb begin
        pick_o   = '0;
        any_pend = 1'b0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (pending_q[i]) begin
                pick_o   = IDX_W'(i);
                any_pend = 1'b1;
            end
        end
    end

    assign launch_o = any_pend && !busy_o;

    // one-hot grant for the slot leaving the pending set
    always_comb begin
        grant = '0;
        if (launch_o) grant[pick_o] = 1'b1;
    end

    // pending set: new requests win over the grant that removes them
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= (pending_q & ~grant) | req_set;
    end

    // converter occupancy and the slot currently converting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o   <= 1'b0;
            active_o <= '0;
        end else if (launch_o) begin
            busy_o   <= 1'b1;
            active_o <= pick_o;
        end else if (done_in) begin
            busy_o   <= 1'b0;
        end
    end

    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R7
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> busy_o && !launch_o);
    // R7
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_in |=> busy_o && $stable(active_o));
endmodule

// File: rtl/slot_unit.sv
// One virtual slot: the mode flag, the sample count, the result and the
// sample progress counter. It captures or accumulates routed samples.
// Assumes a register write in the same cycle as a sample takes precedence;
// that sample is dropped and reports no completion.
module slot_unit #(
    parameter int RES_W = 18,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             acc_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [RES_W-1:0] val_in,
    input  logic             done_in,
    input  logic [RES_W-1:0] sample_in,
    output logic             acc_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [RES_W-1:0] val_o,
    output logic             cmpl_o
);
    logic [CNT_W-1:0] prog_q;
    logic             last;

    assign last   = !acc_o || (prog_q == cnt_o);
    assign cmpl_o = done_in && !wr_en && last;

    // configuration load, capture or accumulate, progress tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o  <= 1'b0;
            cnt_o  <= '0;
            val_o  <= '0;
            prog_q <= '0;
        end else if (wr_en) begin
            acc_o  <= acc_in;
            cnt_o  <= cnt_in;
            val_o  <= val_in;
            prog_q <= '0;
        end else if (done_in) begin
            if (acc_o) begin
                val_o  <= val_o + sample_in;
                prog_q <= last ? '0 : prog_q + 1'b1;
            end else begin
                val_o  <= sample_in;
            end
        end
    end

    // R5
    zero_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !acc_in && cnt_in == '0 && val_in == '0 |=> val_o == '0 && prog_q == '0);
    // R4
    val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !done_in |=> $stable(val_o) && $stable(prog_q));
endmodule

// File: rtl/irq_ctrl.sv
// Sticky completion status, per-slot enables and the combined interrupt.
// Assumes a completion in the same cycle as a clear of that bit leaves the bit set.
module irq_ctrl #(
    parameter int N_SLOTS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] set_in,
    input  logic               en_wr,
    input  logic [N_SLOTS-1:0] en_data,
    input  logic [N_SLOTS-1:0] clr_stat,
    input  logic [N_SLOTS-1:0] clr_en,
    output logic [N_SLOTS-1:0] status_o,
    output logic [N_SLOTS-1:0] enable_o,
    output logic               irq_o
);
    // status: set by completion, cleared by the alias, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_stat) | set_in;
    end

    // enables: direct load or alias clear
    always_ff @(posedge clk) begin
        if (!rst_n)     enable_o <= '0;
        else if (en_wr) enable_o <= en_data;
        else            enable_o <= enable_o & ~clr_en;
    end

    assign irq_o = |(status_o & enable_o);

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_chk
        // R8
        sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
            status_o[i] && !clr_stat[i] |=> status_o[i]);
        // R8
        status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !status_o[i] && !set_in[i] |=> !status_o[i]);
    end
endmodule

// File: rtl/adc_slot_seq.sv
// Top of the slot sequencer: register decode, channel map, read mux,
// and the per-slot units, the arbiter and the interrupt logic.
// Assumes at most 8 slots, so that all slot registers fit the 4-bit address space.
module adc_slot_seq
    import adc_seq_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int SEL_W   = 4,
    parameter int RES_W   = 18,
    parameter int CNT_W   = 5,
    localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int MAP_W  = N_SLOTS * SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [N_SLOTS-1:0] sched_start,
    output logic               conv_start,
    output logic [SEL_W-1:0]   conv_chan,
    input  logic               conv_done,
    input  logic [RES_W-1:0]   conv_data,
    output logic               irq
);
    logic [MAP_W-1:0]   map_q;
    logic [N_SLOTS-1:0] req_set, slot_wr, slot_done, cmpl;
    logic [N_SLOTS-1:0] status, enable;
    logic [N_SLOTS-1:0] acc_v;
    logic [CNT_W-1:0]   cnt_v [N_SLOTS];
    logic [RES_W-1:0]   val_v [N_SLOTS];
    logic [IDX_W-1:0]   pick, active;
    logic               busy, routed_done;
    logic               wr_irq, wr_clr, wr_map, wr_start, wr_slot;
    logic               unused_bits;

    assign wr_irq   = wr_en && wr_addr == A_IRQ;
    assign wr_clr   = wr_en && wr_addr == A_CLR;
    assign wr_map   = wr_en && wr_addr == A_MAP;
    assign wr_start = wr_en && wr_addr == A_START;
    assign wr_slot  = wr_en && wr_addr[ADDR_W-1];
    assign unused_bits = ^{wr_data[DATA_W-1:ACC_POS+1], wr_data[CNT_POS-1:RES_W]};

    // start requests from software and scheduler
    assign req_set = sched_start | (wr_start ? wr_data[N_SLOTS-1:0] : '0);

    // channel map register
    always_ff @(posedge clk) begin
        if (!rst_n)      map_q <= '0;
        else if (wr_map) map_q <= wr_data[MAP_W-1:0];
    end

    seq_arbiter #(.N_SLOTS(N_SLOTS)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .done_in(routed_done),
        .launch_o(conv_start), .pick_o(pick), .busy_o(busy), .active_o(active)
    );

    assign routed_done = conv_done && busy;
    assign conv_chan   = map_q[pick*SEL_W +: SEL_W];

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        assign slot_wr[s]   = wr_slot && wr_addr[IDX_W-1:0] == IDX_W'(s);
        assign slot_done[s] = routed_done && active == IDX_W'(s);
        slot_unit #(.RES_W(RES_W), .CNT_W(CNT_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .wr_en(slot_wr[s]),
            .acc_in(wr_data[ACC_POS]), .cnt_in(wr_data[CNT_POS +: CNT_W]),
            .val_in(wr_data[RES_W-1:0]), .done_in(slot_done[s]),
            .sample_in(conv_data), .acc_o(acc_v[s]), .cnt_o(cnt_v[s]),
            .val_o(val_v[s]), .cmpl_o(cmpl[s])
        );
    end

    irq_ctrl #(.N_SLOTS(N_SLOTS)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_in(cmpl), .en_wr(wr_irq),
        .en_data(wr_data[EN_POS +: N_SLOTS]), .clr_stat(wr_clr ? wr_data[N_SLOTS-1:0] : '0),
        .clr_en(wr_clr ? wr_data[EN_POS +: N_SLOTS] : '0),
        .status_o(status), .enable_o(enable), .irq_o(irq)
    );

    // register read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr[ADDR_W-1]) begin
            rd_data[ACC_POS]           = acc_v[rd_addr[IDX_W-1:0]];
            rd_data[CNT_POS +: CNT_W]  = cnt_v[rd_addr[IDX_W-1:0]];
            rd_data[RES_W-1:0]         = val_v[rd_addr[IDX_W-1:0]];
        end else if (rd_addr == A_IRQ) begin
            rd_data[N_SLOTS-1:0]       = status;
            rd_data[EN_POS +: N_SLOTS] = enable;
        end else if (rd_addr == A_MAP) begin
            rd_data[MAP_W-1:0]         = map_q;
        end
    end

    // R7
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !conv_done |=> !conv_start);
    // R3
    cmpl_routed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |cmpl |-> routed_done);
endmodule

// File: tb/adc_slot_seq_tb.sv
`timescale 1ns/1ps
module adc_slot_seq_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [3:0]  wr_addr = 0;
    logic [31:0] wr_data = 0;
    logic [3:0]  rd_addr = 0;
    logic [31:0] rd_data;
    logic [7:0]  sched_start = 0;
    logic        conv_start;
    logic [3:0]  conv_chan;
    logic        conv_done = 0;
    logic [17:0] conv_data = 0;
    logic        irq;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [17:0] chan_val [16];
    logic [3:0]  log_ch [64];
    int          nlog = 0;
    int          lat_cnt = 0;
    logic [3:0]  cur_ch = 0;
    logic [31:0] map_sh = 0;

    always #2.5 clk = ~clk;

    adc_slot_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sched_start(sched_start),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_data(conv_data), .irq(irq)
    );

    // behavioural converter: fixed latency, value per channel, logs requests
    always @(negedge clk) begin
        conv_done <= 0;
        if (conv_start && rst_n) begin
            cur_ch  <= conv_chan;
            lat_cnt <= 3;
            if (nlog < 64) log_ch[nlog] = conv_chan;
            nlog = nlog + 1;
        end else if (lat_cnt > 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                conv_done <= 1;
                conv_data <= chan_val[cur_ch];
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic conv(int s);
        wr(4'd5, 32'h1 << s);
        repeat (10) @(negedge clk);
    endtask

    function automatic logic [31:0] slot_word(bit acc, int cnt, logic [17:0] v);
        return {2'b0, acc, 5'(cnt), 6'b0, v};
    endfunction

    function automatic logic [17:0] exp_sum(logic [17:0] v, int n);
        longint t;
        t = longint'(v) * n;
        return t[17:0];
    endfunction

    task automatic set_map(int s, int ch);
        map_sh[s*4 +: 4] = 4'(ch);
        wr(4'd4, map_sh);
    endtask

    initial begin
        logic [31:0] d;
        int cnt1;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) chan_val[i] = 18'(i * 1111 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, d); chk("R1 irq reg", d, 0);
        rd(4'd4, d); chk("R1 map", d, 0);
        for (int s = 0; s < 8; s++) begin rd(4'(8 + s), d); chk("R1 slot", d, 0); end
        chk("R1 irq pin", {31'b0, irq}, 0);
        chk("R1 conv_start", {31'b0, conv_start}, 0);

        // R2 R3 R8: slot 3 mapped to channel 9, enable off
        set_map(3, 9);
        nlog = 0;
        conv(3);
        chk("R2 channel", {28'b0, log_ch[0]}, 9);
        rd(4'd11, d); chk("R3 result", d, {14'b0, chan_val[9]});
        rd(4'd0, d); chk("R8 status without enable", d, 32'h8);
        chk("R8 irq low", {31'b0, irq}, 0);
        wr(4'd0, 32'h8 << 16);
        chk("R8 irq high", {31'b0, irq}, 1);
        chan_val[9] = 18'h155;
        conv(3);
        rd(4'd11, d); chk("R3 overwrite", d, 32'h155);
        // R9 clear alias
        wr(4'd3, 32'h8);
        rd(4'd0, d); chk("R9 status cleared", d, 32'h8 << 16);
        chk("R9 irq low", {31'b0, irq}, 0);
        wr(4'd3, 32'h8 << 16);
        rd(4'd0, d); chk("R9 enable cleared", d, 0);

        // R7 ascending issue order
        for (int s = 0; s < 8; s++) map_sh[s*4 +: 4] = 4'(15 - s);
        wr(4'd4, map_sh);
        nlog = 0;
        wr(4'd5, 32'hA5);
        repeat (40) @(negedge clk);
        chk("R7 count", nlog, 4);
        chk("R7 first", {28'b0, log_ch[0]}, 15);
        chk("R7 second", {28'b0, log_ch[1]}, 13);
        chk("R7 third", {28'b0, log_ch[2]}, 10);
        chk("R7 fourth", {28'b0, log_ch[3]}, 8);

        // R6 scheduler start on slot 6 (channel 9)
        wr(4'd3, 32'hFF);
        nlog = 0;
        @(negedge clk); sched_start = 8'h40;
        @(negedge clk); sched_start = 0;
        repeat (10) @(negedge clk);
        rd(4'd14, d); chk("R6 sched result", d, {14'b0, chan_val[9]});
        rd(4'd0, d); chk("R6 sched status", d, 32'h40);

        // R10 duplicate starts while busy merge
        nlog = 0;
        wr(4'd5, 32'h1);
        wr(4'd5, 32'h2);
        wr(4'd5, 32'h2);
        repeat (30) @(negedge clk);
        cnt1 = 0;
        for (int i = 0; i < nlog && i < 64; i++) if (log_ch[i] == 4'd14) cnt1++;
        chk("R10 merged", cnt1, 1);
        chk("R10 total", nlog, 2);

        // R4 accumulate, count 3, slot 2 -> channel 4
        set_map(2, 4);
        chan_val[4] = 18'd100;
        wr(4'd3, 32'hFF);
        wr(4'd10, slot_word(1, 3, 0));
        conv(2); conv(2); conv(2);
        rd(4'd0, d); chk("R4 not yet", d, 0);
        rd(4'd10, d); chk("R4 partial", d, slot_word(1, 3, 300));
        conv(2);
        rd(4'd0, d); chk("R4 done", d, 32'h4);
        rd(4'd10, d); chk("R4 sum", d, slot_word(1, 3, 400));
        // R5 zero write clears
        wr(4'd10, 0);
        rd(4'd10, d); chk("R5 cleared", d, 0);
        conv(2);
        rd(4'd10, d); chk("R5 fresh capture", d, 100);
        // R4 wrap
        chan_val[4] = 18'h3FFFF;
        wr(4'd3, 32'hFF);
        wr(4'd10, slot_word(1, 1, 0));
        conv(2); conv(2);
        rd(4'd10, d); chk("R4 wrap", d, slot_word(1, 1, 18'h3FFFE));

        // random slot programs (R2 R3 R4)
        for (int it = 0; it < 16; it++) begin
            int s, ch, cnt, n;
            bit acc;
            logic [17:0] v;
            s = $urandom % 8; ch = $urandom % 16; acc = 1'($urandom % 2);
            cnt = $urandom % 4; v = 18'($urandom);
            chan_val[ch] = v;
            set_map(s, ch);
            wr(4'd3, 32'hFF);
            wr(4'(8 + s), slot_word(acc, cnt, 0));
            n = acc ? cnt + 1 : 1;
            for (int k = 0; k < n - 1; k++) conv(s);
            if (n > 1) begin rd(4'd0, d); chk("R4 rand pending", d, 0); end
            conv(s);
            rd(4'(8 + s), d); chk("R4 rand result", d, slot_word(acc, cnt, exp_sum(v, n)));
            rd(4'd0, d); chk("R3 rand status", d, 32'h1 << s);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule